// File: doc/BRIEF.md
# Weighted Delay-and-Sum Beamformer

This block forms several steered beams from a small sensor array in the time domain. Once per sample period it takes one frame holding one two's-complement sample per sensor and stores the frame in a circular history kept for each sensor. It then computes the beams one at a time, in order of beam index. For every sensor, the datapath reads the sample that is a programmed whole number of frames old, multiplies that sample by a programmed 16-bit weight, and adds the product into a wide fixed-point sum. The sum is shifted right arithmetically by a programmed amount and saturated to the selected output width. That result leaves as one beam sample.

Each beam has its own delay and weight for every sensor. All beams read the same sample history, so a single multiply-accumulate datapath serves several look directions. On a line array, the delays steer a beam. Each sensor's delay is a multiple of the sound travel time between neighbouring sensors, and that multiple depends on the arrival angle. The weights shape the beam's passband.

Frames enter on a valid/ready stream. An input frame transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from the moment a frame is accepted until the last beam of that frame has been handed over. The beam stream is also valid/ready. A beam sample transfers on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered beam sample and its index hold steady, and the datapath waits. Tables are written through a plain register-write port into shadow copies. Each accepted frame copies the shadow copies into the working tables, so one frame never sees a mix of old and new settings. `HIST_DEPTH` must be a power of two.

Top module: `bf_beamformer`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. All weights, delays, the shift amount and the whole sample history are zero, so a first frame produces beam samples of 0.
- R2: In wide mode (`narrow_mode`=0), beam b equals sat16((sum over sensors s of x_s[n - d(b,s)] * w(b,s)) >>> shift). Sensor s is carried in `in_data[16*s+15:16*s]`. The sum is exact, with no overflow inside it.
- R3: A delay of 0 selects the sample of the frame being processed. A delay of k selects the sample accepted k frames earlier. A position that no frame has filled since reset reads as 0. Delays run from 0 to `HIST_DEPTH`-1.
- R4: In narrow mode (`narrow_mode`=1), each lane contributes only its low 8 bits, sign-extended, and the upper byte has no effect. The result saturates to [-128, 127] and is presented sign-extended on the 16-bit `out_data`.
- R5: In wide mode the result saturates to [-32768, 32767].
- R6: The beams of a frame are emitted in ascending index order, 0 to `NUM_BEAMS`-1. `out_beam` carries the index of the beam being offered.
- R7: Once a frame is accepted, `in_ready` stays 0 until the handshake of that frame's last beam. After that handshake it returns to 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_beam` keep their values.
- R9: A table write with `cfg_we`=1 updates the shadow copy. The write is used only from the next frame accepted after the write, never partway through the current frame. `cfg_kind` selects the table: 0 = weight (16-bit two's complement, from `cfg_data`), 1 = delay (from the low bits of `cfg_data`), 2 = shift amount (from the low bits of `cfg_data`). `cfg_beam` and `cfg_sens` are ignored for the shift amount.
- R10: The right shift is arithmetic, so it rounds toward minus infinity. For example, a sum of -3 shifted by 1 gives -2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| narrow_mode | input | 1 | 1 = 8-bit samples and 8-bit beam range, 0 = 16-bit |
| in_valid | input | 1 | Input frame offered |
| in_ready | output | 1 | Block can accept a frame |
| in_data | input | 16*NUM_SENS | One sample per sensor, sensor s in lane s |
| out_valid | output | 1 | Beam sample offered |
| out_ready | input | 1 | Downstream takes the beam sample |
| out_data | output | 16 | Beam sample, two's complement |
| out_beam | output | BEAM_W | Index of the offered beam |
| cfg_we | input | 1 | Table write strobe |
| cfg_kind | input | 2 | 0 weight, 1 delay, 2 shift amount |
| cfg_beam | input | BEAM_W | Beam index of the entry |
| cfg_sens | input | SENS_W | Sensor index of the entry |
| cfg_data | input | 16 | Value written |

## Verification
The assertions assume three things about the inputs. First, `narrow_mode` changes only while no frame is in progress and no beam sample is waiting, because the range check on `out_data` reads the pin as it is at that moment. Second, reset is applied before the first edge. Third, table writes are not issued on the same edge as a frame acceptance. The bench changes the mode only after the last beam handshake of a frame. It issues table writes only while `in_valid` is low, and it keeps every delay below `HIST_DEPTH`. The bench holds `out_ready` low for several cycles on selected frames, so the hold and ordering properties are exercised under back-pressure.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int SAMP_W   = 16;
  localparam int COEF_W   = 16;
  localparam int OUT_W    = 16;
  localparam int NARROW_W = 8;

  typedef enum logic [1:0] {
    CFG_WEIGHT = 2'd0,
    CFG_DELAY  = 2'd1,
    CFG_SHIFT  = 2'd2
  } cfg_kind_e;
endpackage

// File: rtl/bf_history.sv
module bf_history #(
  parameter int NUM_SENS = 4,
  parameter int DEPTH    = 8,
  parameter int PTR_W    = 3,
  parameter int SAMP_W   = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [NUM_SENS-1:0][SAMP_W-1:0]  wr_samples,
  input  logic [NUM_SENS-1:0][PTR_W-1:0]   rd_delays,
  output logic [NUM_SENS-1:0][SAMP_W-1:0]  rd_samples
);
  // Next slot to be written; the newest sample sits one slot behind it.
  logic [PTR_W-1:0] wr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n)     wr_ptr <= '0;
    else if (wr_en) wr_ptr <= wr_ptr + PTR_W'(1);
  end

  for (genvar s = 0; s < NUM_SENS; s++) begin : g_sens
    logic [SAMP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      end else if (wr_en) begin
        mem[wr_ptr] <= wr_samples[s];
      end
    end

    assign rd_samples[s] = mem[wr_ptr - PTR_W'(1) - rd_delays[s]];
  end
endmodule

// File: rtl/bf_coef_tables.sv
module bf_coef_tables #(
  parameter int NUM_SENS  = 4,
  parameter int NUM_BEAMS = 2,
  parameter int BEAM_W    = 1,
  parameter int SENS_W    = 2,
  parameter int PTR_W     = 3,
  parameter int SHIFT_W   = 6,
  parameter int COEF_W    = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [1:0]                       cfg_kind,
  input  logic [BEAM_W-1:0]                cfg_beam,
  input  logic [SENS_W-1:0]                cfg_sens,
  input  logic [15:0]                      cfg_data,
  input  logic                             commit,
  input  logic [BEAM_W-1:0]                rd_beam,
  output logic [NUM_SENS-1:0][COEF_W-1:0]  rd_weights,
  output logic [NUM_SENS-1:0][PTR_W-1:0]   rd_delays,
  output logic [SHIFT_W-1:0]               rd_shift
);
  import bf_pkg::*;

  logic [COEF_W-1:0]  sh_w  [NUM_BEAMS][NUM_SENS];
  logic [COEF_W-1:0]  act_w [NUM_BEAMS][NUM_SENS];
  logic [PTR_W-1:0]   sh_d  [NUM_BEAMS][NUM_SENS];
  logic [PTR_W-1:0]   act_d [NUM_BEAMS][NUM_SENS];
  logic [SHIFT_W-1:0] sh_shift, act_shift;

  logic in_range;
  assign in_range = (int'(cfg_beam) < NUM_BEAMS) && (int'(cfg_sens) < NUM_SENS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BEAMS; b++) begin
        for (int s = 0; s < NUM_SENS; s++) begin
          sh_w[b][s]  <= '0;
          act_w[b][s] <= '0;
          sh_d[b][s]  <= '0;
          act_d[b][s] <= '0;
        end
      end
      sh_shift  <= '0;
      act_shift <= '0;
    end else begin
      if (cfg_we) begin
        if (cfg_kind == CFG_WEIGHT && in_range) sh_w[cfg_beam][cfg_sens] <= cfg_data[COEF_W-1:0];
        if (cfg_kind == CFG_DELAY  && in_range) sh_d[cfg_beam][cfg_sens] <= cfg_data[PTR_W-1:0];
        if (cfg_kind == CFG_SHIFT)              sh_shift <= cfg_data[SHIFT_W-1:0];
      end
      // Frame boundary: the working set takes the staged values.
      if (commit) begin
        act_w     <= sh_w;
        act_d     <= sh_d;
        act_shift <= sh_shift;
      end
    end
  end

  for (genvar s = 0; s < NUM_SENS; s++) begin : g_rd
    assign rd_weights[s] = act_w[rd_beam][s];
    assign rd_delays[s]  = act_d[rd_beam][s];
  end
  assign rd_shift = act_shift;
endmodule

// File: rtl/bf_combiner.sv
module bf_combiner #(
  parameter int NUM_SENS = 4,
  parameter int SAMP_W   = 16,
  parameter int COEF_W   = 16,
  parameter int ACC_W    = 34,
  parameter int SHIFT_W  = 6,
  parameter int OUT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic [NUM_SENS-1:0][SAMP_W-1:0] samples,
  input  logic [NUM_SENS-1:0][COEF_W-1:0] weights,
  input  logic [SHIFT_W-1:0]              shift,
  input  logic                            narrow,
  output logic [OUT_W-1:0]                result
);
  localparam logic signed [ACC_W-1:0] WIDE_HI   = (ACC_W'(1) << (OUT_W-1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] WIDE_LO   = -(ACC_W'(1) << (OUT_W-1));
  localparam logic signed [ACC_W-1:0] NARROW_HI = (ACC_W'(1) << (NARROW_W-1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] NARROW_LO = -(ACC_W'(1) << (NARROW_W-1));

  logic signed [SAMP_W+COEF_W-1:0] prod;
  logic signed [ACC_W-1:0]         acc, shifted, hi, lo, clipped;

  always_comb begin
    acc  = '0;
    prod = '0;
    for (int s = 0; s < NUM_SENS; s++) begin
      prod = $signed(samples[s]) * $signed(weights[s]);
      acc  = acc + ACC_W'(prod);
    end
    shifted = acc >>> shift;
    hi = narrow ? NARROW_HI : WIDE_HI;
    lo = narrow ? NARROW_LO : WIDE_LO;
    if (shifted > hi)      clipped = hi;
    else if (shifted < lo) clipped = lo;
    else                   clipped = shifted;
    result = clipped[OUT_W-1:0];
  end
endmodule

// File: rtl/bf_beamformer.sv
module bf_beamformer #(
  parameter int NUM_SENS   = 4,
  parameter int NUM_BEAMS  = 2,
  parameter int HIST_DEPTH = 8,
  localparam int BEAM_W    = (NUM_BEAMS > 1) ? $clog2(NUM_BEAMS) : 1,
  localparam int SENS_W    = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     narrow_mode,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NUM_SENS*16-1:0]   in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [15:0]              out_data,
  output logic [BEAM_W-1:0]        out_beam,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_kind,
  input  logic [BEAM_W-1:0]        cfg_beam,
  input  logic [SENS_W-1:0]        cfg_sens,
  input  logic [15:0]              cfg_data
);
  import bf_pkg::*;

  localparam int PTR_W   = (HIST_DEPTH > 1) ? $clog2(HIST_DEPTH) : 1;
  localparam int ACC_W   = SAMP_W + COEF_W + $clog2(NUM_SENS);
  localparam int SHIFT_W = $clog2(ACC_W);
  localparam logic [BEAM_W-1:0] LAST_BEAM = BEAM_W'(NUM_BEAMS - 1);

  logic                            busy;
  logic [BEAM_W-1:0]               beam_idx;
  logic                            accept, load;
  logic [NUM_SENS-1:0][SAMP_W-1:0] ext_samples, hist_samples;
  logic [NUM_SENS-1:0][COEF_W-1:0] weights;
  logic [NUM_SENS-1:0][PTR_W-1:0]  delays;
  logic [SHIFT_W-1:0]              shift;
  logic [OUT_W-1:0]                beam_value;

  assign in_ready = !busy && !out_valid;
  assign accept   = in_valid && in_ready;
  assign load     = busy && (!out_valid || out_ready);

  // Lane extension: narrow mode keeps only the low byte, sign-extended.
  for (genvar s = 0; s < NUM_SENS; s++) begin : g_ext
    assign ext_samples[s] = narrow_mode
      ? {{(SAMP_W-NARROW_W){in_data[s*16+NARROW_W-1]}}, in_data[s*16 +: NARROW_W]}
      : in_data[s*16 +: SAMP_W];
  end

  bf_history #(
    .NUM_SENS(NUM_SENS), .DEPTH(HIST_DEPTH), .PTR_W(PTR_W), .SAMP_W(SAMP_W)
  ) u_history (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_samples(ext_samples),
    .rd_delays(delays), .rd_samples(hist_samples)
  );

  bf_coef_tables #(
    .NUM_SENS(NUM_SENS), .NUM_BEAMS(NUM_BEAMS), .BEAM_W(BEAM_W), .SENS_W(SENS_W),
    .PTR_W(PTR_W), .SHIFT_W(SHIFT_W), .COEF_W(COEF_W)
  ) u_tables (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_beam(cfg_beam), .cfg_sens(cfg_sens), .cfg_data(cfg_data),
    .commit(accept), .rd_beam(beam_idx),
    .rd_weights(weights), .rd_delays(delays), .rd_shift(shift)
  );

  bf_combiner #(
    .NUM_SENS(NUM_SENS), .SAMP_W(SAMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
    .SHIFT_W(SHIFT_W), .OUT_W(OUT_W), .NARROW_W(NARROW_W)
  ) u_combiner (
    .samples(hist_samples), .weights(weights), .shift(shift),
    .narrow(narrow_mode), .result(beam_value)
  );

  // Beam sequencer and output register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      beam_idx  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_beam  <= '0;
    end else begin
      if (accept) begin
        busy     <= 1'b1;
        beam_idx <= '0;
      end
      if (load) begin
        out_valid <= 1'b1;
        out_data  <= beam_value;
        out_beam  <= beam_idx;
        if (beam_idx == LAST_BEAM) busy <= 1'b0;
        else                       beam_idx <= beam_idx + BEAM_W'(1);
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bf_beamformer_chk.sv
module bf_beamformer_chk #(
  parameter int NUM_BEAMS = 2,
  parameter int BEAM_W    = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              narrow_mode,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [15:0]       out_data,
  input logic [BEAM_W-1:0] out_beam
);
  localparam logic [BEAM_W-1:0] TOP_BEAM = BEAM_W'(NUM_BEAMS - 1);

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_beam));

  // R7
  closed_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  // R7
  no_beam_at_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> !out_valid);

  // R6
  beam_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_beam != TOP_BEAM
    |=> out_valid && out_beam == BEAM_W'($past(out_beam) + BEAM_W'(1)));

  // R4
  narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && narrow_mode |-> ($signed(out_data) <= 16'sd127) && ($signed(out_data) >= -16'sd128));
endmodule

bind bf_beamformer bf_beamformer_chk #(.NUM_BEAMS(NUM_BEAMS), .BEAM_W(BEAM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_beam(out_beam)
);

// File: tb/test_bf_beamformer.sv
module test_bf_beamformer;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NB = 2;
  localparam int HD = 8;
  localparam int NFR = 8;

  // Stimulus table, lane s in bits [16*s+15:16*s]; expected beams come from the model below.
  localparam logic [63:0] FRAMES [0:NFR-1] = '{
    64'h0001_0002_0003_0004,
    64'hFFFF_0010_0020_0005,
    64'h0100_FF00_0007_0009,
    64'h0000_0000_0000_0000,
    64'h7FFF_8000_1234_EDCB,
    64'h0011_0022_0033_0044,
    64'hFFF0_000F_FF01_00FF,
    64'h0003_FFFD_0002_FFFE
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        narrow_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic [0:0]  out_beam;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [0:0]  cfg_beam = '0;
  logic [1:0]  cfg_sens = '0;
  logic [15:0] cfg_data = '0;

  bf_beamformer #(.NUM_SENS(NS), .NUM_BEAMS(NB), .HIST_DEPTH(HD)) i_bf_beamformer (
    .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_beam(out_beam),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_beam(cfg_beam), .cfg_sens(cfg_sens),
    .cfg_data(cfg_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Independent model state.
  int hist [0:255][0:NS-1];
  int nfr = 0;
  int sh_w [0:NB-1][0:NS-1];
  int ac_w [0:NB-1][0:NS-1];
  int sh_d [0:NB-1][0:NS-1];
  int ac_d [0:NB-1][0:NS-1];
  int sh_sh = 0;
  int ac_sh = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lane_value(logic [63:0] fr, int s);
    logic [15:0] v;
    v = fr[16*s +: 16];
    if (narrow_mode) return int'($signed(v[7:0]));
    return int'($signed(v));
  endfunction

  function automatic int model_beam(int b);
    longint acc = 0;
    longint hi, lo;
    for (int s = 0; s < NS; s++) begin
      int idx;
      longint smp;
      idx = nfr - 1 - ac_d[b][s];
      smp = (idx >= 0) ? longint'(hist[idx][s]) : 0;
      acc += smp * longint'(ac_w[b][s]);
    end
    acc = acc >>> ac_sh;
    hi = narrow_mode ? 127 : 32767;
    lo = narrow_mode ? -128 : -32768;
    if (acc > hi) acc = hi;
    if (acc < lo) acc = lo;
    return int'(acc);
  endfunction

  // Called at a negedge; returns at the next negedge.
  task automatic cfg_write(int kind, int beam, int sens, int data);
    cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_beam = 1'(beam); cfg_sens = 2'(sens); cfg_data = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (kind == 0) sh_w[beam][sens] = int'($signed(16'(data)));
    if (kind == 1) sh_d[beam][sens] = data;
    if (kind == 2) sh_sh = data;
  endtask

  task automatic set_beam(int b, int w0, int w1, int w2, int w3, int d0, int d1, int d2, int d3);
    cfg_write(0, b, 0, w0); cfg_write(0, b, 1, w1); cfg_write(0, b, 2, w2); cfg_write(0, b, 3, w3);
    cfg_write(1, b, 0, d0); cfg_write(1, b, 1, d1); cfg_write(1, b, 2, d2); cfg_write(1, b, 3, d3);
  endtask

  // Sends one frame and collects its beams. mid_w >= -32768 writes weight (0,0) mid-frame.
  task automatic send_frame(logic [63:0] fr, bit stall, int mid_w, string tag0,
                            output int got0, output int got1);
    int exp_b [0:NB-1];
    int got [0:NB-1];
    in_data = fr;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    ac_w = sh_w; ac_d = sh_d; ac_sh = sh_sh;
    for (int s = 0; s < NS; s++) hist[nfr][s] = lane_value(fr, s);
    nfr++;
    for (int b = 0; b < NB; b++) exp_b[b] = model_beam(b);
    check("R7 in_ready after accept", int'(in_ready), 0);
    out_ready = !stall;
    if (mid_w >= -32768) cfg_write(0, 0, 0, mid_w);
    for (int b = 0; b < NB; b++) begin
      while (!out_valid) @(negedge clk);
      if (stall) begin
        logic [15:0] hd;
        logic [0:0]  hb;
        hd = out_data; hb = out_beam;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          check("R8 valid held", int'(out_valid), 1);
          check("R8 data held", int'(out_data), int'(hd));
          check("R8 beam held", int'(out_beam), int'(hb));
        end
        out_ready = 1'b1;
      end
      check("R6 beam index", int'(out_beam), b);
      got[b] = int'($signed(out_data));
      check((b == 0) ? tag0 : "R3 delayed beam", got[b], exp_b[b]);
      if (b < NB-1) check("R7 in_ready mid-frame", int'(in_ready), 0);
      @(negedge clk);
      if (stall) out_ready = 1'b0;
    end
    out_ready = 1'b0;
    check("R7 in_ready after last beam", int'(in_ready), 1);
    got0 = got[0];
    got1 = got[1];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int g0, g1;
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < NS; s++) begin
        sh_w[b][s] = 0; ac_w[b][s] = 0; sh_d[b][s] = 0; ac_d[b][s] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and zero tables.
    check("R1 in_ready after reset", int'(in_ready), 1);
    check("R1 out_valid after reset", int'(out_valid), 0);
    send_frame(64'h1234_5678_0ABC_7FFF, 1'b0, -99999, "R1 zero tables", g0, g1);
    check("R1 beam1 zero", g1, 0);

    // Table-driven main function.
    set_beam(0, 1, 1, 1, 1, 0, 0, 0, 0);
    set_beam(1, 1, 2, -1, 3, 0, 1, 2, 3);
    for (int i = 0; i < NFR; i++)
      send_frame(FRAMES[i], i[0], -99999, "R2 beam sum", g0, g1);

    // R5: wide saturation both ways.
    set_beam(0, 32767, 32767, 32767, 32767, 0, 0, 0, 0);
    send_frame(64'h7FFF_7FFF_7FFF_7FFF, 1'b0, -99999, "R5 positive clip", g0, g1);
    check("R5 positive clip literal", g0, 32767);
    send_frame(64'h8000_8000_8000_8000, 1'b1, -99999, "R5 negative clip", g0, g1);
    check("R5 negative clip literal", g0, -32768);

    // R10: arithmetic shift rounds toward minus infinity.
    set_beam(0, 1, 1, 1, 1, 0, 0, 0, 0);
    cfg_write(2, 0, 0, 1);
    send_frame(64'h0000_FFFF_FFFF_FFFF, 1'b0, -99999, "R10 shift", g0, g1);
    check("R10 -3 shifted by 1", g0, -2);
    cfg_write(2, 0, 0, 0);

    // R4: narrow mode ignores upper bytes and clips to 8 bits.
    narrow_mode = 1'b1;
    send_frame(64'hFF10_0003_12FE_AB05, 1'b0, -99999, "R4 narrow sum", g0, g1);
    check("R4 upper byte ignored", g0, 22);
    send_frame(64'h557F_007F_AA7F_017F, 1'b1, -99999, "R4 narrow clip", g0, g1);
    check("R4 clip to 127", g0, 127);
    narrow_mode = 1'b0;

    // R9: a write during a frame is used only from the next frame.
    send_frame(64'h0004_0003_0002_0001, 1'b1, 5, "R9 old weight in frame", g0, g1);
    check("R9 old weight literal", g0, 10);
    send_frame(64'h0004_0003_0002_0001, 1'b0, -99999, "R9 new weight next frame", g0, g1);
    check("R9 new weight literal", g0, 14);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule